// File: doc/BRIEF.md
# Indexed Operand Formation Unit

This block takes one 30-bit instruction word at a time and produces the effective address and the 30-bit operand that a read-class instruction works on. The 15-bit operand designator is optionally offset by one of seven 15-bit index registers. The offset uses ones' complement arithmetic with end-around carry, so the sum is taken modulo 2^15-1. A 3-bit interpretation code then selects the operand. It can be the address itself (zero-filled or sign-filled), either half of a memory word (zero-filled or sign-filled), the whole memory word, or the accumulator.

The unit drives a combinational read port into an external index register file. It raises a single read request on a simple request/acknowledge memory port when the operand lives in memory. It takes the accumulator value as a plain input. Results leave as a one-cycle `op_valid` pulse, which carries the operand, the effective address, the function code and the branch condition field. An illegal function code produces a one-cycle `fault` pulse instead of an operand.

Top module: `opf_unit`

## Requirements
- R1: Instruction fields are decoded at fixed positions: function code bits 29..24, branch condition bits 23..21, interpretation code bits 20..18, index select bits 17..15, operand designator bits 14..0. With `op_valid`, `op_func` and `op_bcond` carry the function code and branch condition of the instruction that produced the operand.
- R2: When the index select is 0, `op_addr` equals the operand designator unchanged.
- R3: When the index select is 1 to 7, `op_addr` is the designator plus the selected index register modulo 2^15-1, with the carry out of bit 14 added back into bit 0. The result is all zeros only when both the designator and the index value are all zeros.
- R4: Interpretation 0 gives upper half zero and lower half equal to the effective address. Interpretation 4 gives the effective address in the lower half and effective address bit 14 copied into all 15 upper bits.
- R5: Interpretation 1 gives upper half zero and lower half equal to memory bits 14..0. Interpretation 2 gives upper half zero and lower half equal to memory bits 29..15.
- R6: Interpretation 3 gives the full 30-bit memory word.
- R7: Interpretation 5 gives memory bits 14..0 in the lower half with memory bit 14 filling the upper half. Interpretation 6 gives memory bits 29..15 in the lower half with memory bit 29 filling the upper half.
- R8: Interpretation 7 gives the value of `acc_in` sampled when the instruction is accepted, and no memory request is made. For interpretations 0, 4 and 7, `op_valid` pulses in the cycle after acceptance.
- R9: A memory read with `mem_addr` equal to the effective address is requested only for interpretations 1, 2, 3, 5 and 6. `mem_req` rises in the cycle after acceptance and holds with a stable address until `mem_ack` is sampled high. `op_valid` pulses in the cycle after that acknowledge.
- R10: A function code of 00 or 77 (octal) gives a one-cycle `fault` pulse in the cycle after acceptance, with no `op_valid` and no memory request.
- R11: `instr_ready` is low while a memory read is outstanding. An instruction presented while `instr_ready` is low is not accepted and has no effect on any output.
- R12: After reset, `op_valid`, `fault` and `mem_req` are low and `instr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction word is presented |
| instr_word | input | 30 | Instruction word |
| instr_ready | output | 1 | Unit can accept an instruction this cycle |
| idx_sel | output | 3 | Index register number for the register file read port |
| idx_data | input | 15 | Index register contents, valid in the same cycle as `idx_sel` |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 15 | Memory read address |
| mem_ack | input | 1 | Memory read data is valid |
| mem_rdata | input | 30 | Memory read data |
| acc_in | input | 30 | Accumulator contents |
| op_valid | output | 1 | One-cycle pulse: operand outputs are valid |
| op_data | output | 30 | Formed operand |
| op_addr | output | 15 | Effective address |
| op_func | output | 6 | Function code of the instruction |
| op_bcond | output | 3 | Branch condition field of the instruction |
| fault | output | 1 | One-cycle pulse: illegal function code |

## Verification
The assertions assume that the index register file answers combinationally, so `idx_data` matches `idx_sel` in the same cycle. They also assume the memory raises `mem_ack` only while `mem_req` is high, with `mem_rdata` valid in that cycle. The bench keeps to both assumptions. Its index file is an array read continuously through `idx_sel`. Its memory responder acknowledges only an observed request, after a per-instruction delay of zero to three cycles, and drops the acknowledge straight after.

// File: rtl/opf_pkg.sv
// Shared definitions for the operand formation unit.
// Assumes a 3-bit interpretation code and 3-bit selector fields.
package opf_pkg;
    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        INT_IMM    = 3'd0,
        INT_LO     = 3'd1,
        INT_HI     = 3'd2,
        INT_FULL   = 3'd3,
        INT_IMM_SX = 3'd4,
        INT_LO_SX  = 3'd5,
        INT_HI_SX  = 3'd6,
        INT_ACC    = 3'd7
    } interp_e;

    // True when the interpretation draws its operand from memory.
    function automatic logic needs_mem(interp_e code);
        return (code == INT_LO) || (code == INT_HI) || (code == INT_FULL) ||
               (code == INT_LO_SX) || (code == INT_HI_SX);
    endfunction
endpackage

// File: rtl/opf_eac_adder.sv
// Ones' complement adder with end-around carry, modulo 2^W-1.
// Purely combinational; a zero result occurs only for two zero inputs.
module opf_eac_adder #(
    parameter int W = 15
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    logic [W:0] raw;

    // Plain binary sum, then fold the carry back into bit 0.
    always_comb begin
        raw = {1'b0, a} + {1'b0, b};
        sum = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
    end
endmodule

// File: rtl/opf_fields.sv
// Splits an instruction word into its fields and flags illegal function codes.
// Assumes the word is 2*HALF_W bits with three SEL_W-bit selectors above the designator.
module opf_fields
    import opf_pkg::*;
#(
    parameter  int HALF_W = 15,
    localparam int WORD_W = 2 * HALF_W,
    localparam int FUNC_W = WORD_W - HALF_W - 3 * SEL_W
) (
    input  logic [WORD_W-1:0] word,
    output logic [FUNC_W-1:0] func,
    output logic [SEL_W-1:0]  bcond,
    output interp_e           interp,
    output logic [SEL_W-1:0]  idx,
    output logic [HALF_W-1:0] desig,
    output logic              illegal
);
    // Field extraction at fixed positions and illegal-code detection.
    always_comb begin
        func    = word[WORD_W-1 -: FUNC_W];
        bcond   = word[HALF_W+3*SEL_W-1 -: SEL_W];
        interp  = interp_e'(word[HALF_W+2*SEL_W-1 -: SEL_W]);
        idx     = word[HALF_W+SEL_W-1 -: SEL_W];
        desig   = word[HALF_W-1:0];
        illegal = (func == '0) || (func == '1);
    end
endmodule

// File: rtl/opf_shaper.sv
// Builds the operand from the interpretation code.
// Sources: effective address, memory word halves, full word, accumulator.
module opf_shaper
    import opf_pkg::*;
#(
    parameter  int HALF_W = 15,
    localparam int WORD_W = 2 * HALF_W
) (
    input  interp_e           interp,
    input  logic [HALF_W-1:0] ea,
    input  logic [WORD_W-1:0] mem_word,
    input  logic [WORD_W-1:0] acc,
    output logic [WORD_W-1:0] operand
);
    logic [HALF_W-1:0] lo_half;
    logic [HALF_W-1:0] hi_half;

    assign lo_half = mem_word[HALF_W-1:0];
    assign hi_half = mem_word[WORD_W-1:HALF_W];

    // Operand selection with zero or sign fill of the upper half.
    always_comb begin
        case (interp)
            INT_IMM:    operand = {{HALF_W{1'b0}}, ea};
            INT_IMM_SX: operand = {{HALF_W{ea[HALF_W-1]}}, ea};
            INT_LO:     operand = {{HALF_W{1'b0}}, lo_half};
            INT_HI:     operand = {{HALF_W{1'b0}}, hi_half};
            INT_FULL:   operand = mem_word;
            INT_LO_SX:  operand = {{HALF_W{lo_half[HALF_W-1]}}, lo_half};
            INT_HI_SX:  operand = {{HALF_W{hi_half[HALF_W-1]}}, hi_half};
            INT_ACC:    operand = acc;
            default:    operand = '0;
        endcase
    end
endmodule

// File: rtl/opf_unit.sv
// Indexed operand formation unit (top).
// Accepts one instruction when idle, forms the effective address through the
// index adder and produces the operand, waiting on one memory read if needed.
// Assumes idx_data answers idx_sel combinationally and mem_ack comes only
// while mem_req is high.
module opf_unit
    import opf_pkg::*;
#(
    parameter  int HALF_W = 15,
    localparam int WORD_W = 2 * HALF_W,
    localparam int FUNC_W = WORD_W - HALF_W - 3 * SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [WORD_W-1:0] instr_word,
    output logic              instr_ready,
    output logic [SEL_W-1:0]  idx_sel,
    input  logic [HALF_W-1:0] idx_data,
    output logic              mem_req,
    output logic [HALF_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic [WORD_W-1:0] acc_in,
    output logic              op_valid,
    output logic [WORD_W-1:0] op_data,
    output logic [HALF_W-1:0] op_addr,
    output logic [FUNC_W-1:0] op_func,
    output logic [SEL_W-1:0]  op_bcond,
    output logic              fault
);
    typedef enum logic {ST_IDLE, ST_MEM} state_e;

    state_e            state;
    logic [FUNC_W-1:0] f_func;
    logic [SEL_W-1:0]  f_bcond;
    interp_e           f_interp;
    logic [SEL_W-1:0]  f_idx;
    logic [HALF_W-1:0] f_desig;
    logic              f_illegal;
    logic [HALF_W-1:0] idx_sum;
    logic [HALF_W-1:0] ea_comb;
    logic [HALF_W-1:0] ea_q;
    interp_e           interp_q;
    interp_e           sh_interp;
    logic [HALF_W-1:0] sh_ea;
    logic [WORD_W-1:0] shaped;

    opf_fields #(.HALF_W(HALF_W)) u_fields (
        .word    (instr_word),
        .func    (f_func),
        .bcond   (f_bcond),
        .interp  (f_interp),
        .idx     (f_idx),
        .desig   (f_desig),
        .illegal (f_illegal)
    );

    opf_eac_adder #(.W(HALF_W)) u_adder (
        .a   (f_desig),
        .b   (idx_data),
        .sum (idx_sum)
    );

    opf_shaper #(.HALF_W(HALF_W)) u_shaper (
        .interp   (sh_interp),
        .ea       (sh_ea),
        .mem_word (mem_rdata),
        .acc      (acc_in),
        .operand  (shaped)
    );

    assign idx_sel     = f_idx;
    assign instr_ready = (state == ST_IDLE);
    assign mem_addr    = ea_q;
    assign op_addr     = ea_q;

    // Effective address: unmodified designator for selector 0, indexed otherwise.
    assign ea_comb = (f_idx == '0) ? f_desig : idx_sum;

    // Shaper inputs come from the new instruction when idle, from held state when waiting.
    always_comb begin
        if (state == ST_IDLE) begin
            sh_interp = f_interp;
            sh_ea     = ea_comb;
        end else begin
            sh_interp = interp_q;
            sh_ea     = ea_q;
        end
    end

    // Control sequence: accept, then issue a result, a fault, or a memory read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            op_valid <= 1'b0;
            fault    <= 1'b0;
            mem_req  <= 1'b0;
            ea_q     <= '0;
            interp_q <= INT_IMM;
            op_func  <= '0;
            op_bcond <= '0;
            op_data  <= '0;
        end else begin
            op_valid <= 1'b0;
            fault    <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (instr_valid) begin
                        op_func  <= f_func;
                        op_bcond <= f_bcond;
                        ea_q     <= ea_comb;
                        interp_q <= f_interp;
                        if (f_illegal) begin
                            fault <= 1'b1;
                        end else if (needs_mem(f_interp)) begin
                            state   <= ST_MEM;
                            mem_req <= 1'b1;
                        end else begin
                            op_valid <= 1'b1;
                            op_data  <= shaped;
                        end
                    end
                end
                ST_MEM: begin
                    if (mem_ack) begin
                        state    <= ST_IDLE;
                        mem_req  <= 1'b0;
                        op_valid <= 1'b1;
                        op_data  <= shaped;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/opf_checker.sv
// Protocol and arithmetic checks for opf_unit, attached by bind.
// Assumes memory acknowledges only an outstanding request.
module opf_checker #(
    parameter int HALF_W = 15,
    parameter int FUNC_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic              instr_ready,
    input logic [FUNC_W-1:0] func_bits,
    input logic [2:0]        interp_bits,
    input logic [2:0]        idx_sel,
    input logic [HALF_W-1:0] desig,
    input logic [HALF_W-1:0] idx_data,
    input logic [HALF_W-1:0] ea_comb,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [HALF_W-1:0] mem_addr,
    input logic              op_valid,
    input logic              fault
);
    logic accept;
    logic legal;
    assign accept = instr_valid && instr_ready;
    assign legal  = (func_bits != '0) && (func_bits != '1);

    AST_EA_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && idx_sel != 3'd0 && ea_comb == '0) |-> (desig == '0 && idx_data == '0)); // R3

    AST_ACC_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && legal && interp_bits == 3'd7) |=> (op_valid && !mem_req)); // R8

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R9

    AST_ACK_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (op_valid && !mem_req)); // R9

    AST_ILLEGAL_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !legal) |=> (fault && !op_valid && !mem_req)); // R10

    AST_FAULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault && op_valid)); // R10

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !instr_ready); // R11
endmodule

bind opf_unit opf_checker #(.HALF_W(HALF_W), .FUNC_W(FUNC_W)) u_opf_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_ready (instr_ready),
    .func_bits   (instr_word[2*HALF_W-1 -: FUNC_W]),
    .interp_bits (instr_word[HALF_W+5 -: 3]),
    .idx_sel     (idx_sel),
    .desig       (instr_word[HALF_W-1:0]),
    .idx_data    (idx_data),
    .ea_comb     (ea_comb),
    .mem_req     (mem_req),
    .mem_ack     (mem_ack),
    .mem_addr    (mem_addr),
    .op_valid    (op_valid),
    .fault       (fault)
);

// File: tb/opf_unit_test.sv
`timescale 1ns/1ps
// Bench for opf_unit: behavioural reference model compared every cycle.
module opf_unit_test;
    localparam int HW = 15;
    localparam int WW = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          instr_valid = 1'b0;
    logic [WW-1:0] instr_word = '0;
    logic          instr_ready;
    logic [2:0]    idx_sel;
    logic [HW-1:0] idx_data;
    logic          mem_req;
    logic [HW-1:0] mem_addr;
    logic          mem_ack = 1'b0;
    logic [WW-1:0] mem_rdata = '0;
    logic [WW-1:0] acc_in = '0;
    logic          op_valid;
    logic [WW-1:0] op_data;
    logic [HW-1:0] op_addr;
    logic [5:0]    op_func;
    logic [2:0]    op_bcond;
    logic          fault;

    always #4 clk = ~clk;

    logic [HW-1:0] xreg [8];
    assign idx_data = xreg[idx_sel];

    opf_unit uut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .instr_ready(instr_ready), .idx_sel(idx_sel), .idx_data(idx_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .acc_in(acc_in), .op_valid(op_valid), .op_data(op_data), .op_addr(op_addr),
        .op_func(op_func), .op_bcond(op_bcond), .fault(fault)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit started = 0;

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Ones' complement sum modulo 32767, written arithmetically.
    function automatic logic [HW-1:0] eac(logic [HW-1:0] a, logic [HW-1:0] b);
        int s;
        s = int'(a) + int'(b);
        if (s > 32767) s = s - 32767;
        return 15'(s);
    endfunction

    function automatic logic [WW-1:0] shape(int it, logic [HW-1:0] ea, logic [WW-1:0] w,
                                            logic [WW-1:0] acc);
        logic [HW-1:0] lo, hi, fill;
        lo = w[14:0];
        hi = w[29:15];
        case (it)
            0: return {15'd0, ea};
            1: return {15'd0, lo};
            2: return {15'd0, hi};
            3: return w;
            4: begin fill = ea[14] ? 15'h7FFF : 15'h0000; return {fill, ea}; end
            5: begin fill = lo[14] ? 15'h7FFF : 15'h0000; return {fill, lo}; end
            6: begin fill = hi[14] ? 15'h7FFF : 15'h0000; return {fill, hi}; end
            default: return acc;
        endcase
    endfunction

    function automatic string data_tag(int it);
        case (it)
            0, 4: return "R4";
            1, 2: return "R5";
            3: return "R6";
            5, 6: return "R7";
            default: return "R8";
        endcase
    endfunction

    // Reference model state.
    bit            m_busy = 0;
    bit            e_opv = 0, e_fault = 0, e_req = 0;
    logic [WW-1:0] e_data = '0;
    logic [HW-1:0] e_addr = '0;
    logic [5:0]    e_func = '0;
    logic [2:0]    e_bc = '0;
    int            m_it = 0;
    int            m_ix = 0;
    bit            in_reset = 1;

    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            in_reset = 1;
            m_busy = 0; e_opv = 0; e_fault = 0; e_req = 0;
        end else begin
            in_reset = 0;
            e_opv = 0;
            e_fault = 0;
            if (!m_busy) begin
                if (instr_valid) begin
                    int f;
                    logic [HW-1:0] d;
                    f = int'(instr_word[29:24]);
                    m_it = int'(instr_word[20:18]);
                    m_ix = int'(instr_word[17:15]);
                    d = instr_word[14:0];
                    e_func = instr_word[29:24];
                    e_bc = instr_word[23:21];
                    e_addr = (m_ix == 0) ? d : eac(d, xreg[m_ix]);
                    if (f == 0 || f == 63) e_fault = 1;
                    else if (m_it == 1 || m_it == 2 || m_it == 3 || m_it == 5 || m_it == 6) begin
                        m_busy = 1;
                        e_req = 1;
                    end else begin
                        e_opv = 1;
                        e_data = shape(m_it, e_addr, '0, acc_in);
                    end
                end
            end else if (mem_ack) begin
                e_opv = 1;
                e_data = shape(m_it, e_addr, mem_rdata, '0);
                e_req = 0;
                m_busy = 0;
            end
        end
    end

    // Memory responder settings, set per instruction.
    int            mem_delay = 0;
    int            mem_cnt = 0;
    logic [HW-1:0] salt_hi = '0, salt_lo = '0;

    // Compare outputs with the model, then act as memory.
    always @(negedge clk) begin
        if (started) begin
            string t;
            t = in_reset ? "R12" : "R9";
            chk(op_valid == e_opv, in_reset ? "R12" : "R9 op_valid", 64'(op_valid), 64'(e_opv));
            chk(fault == e_fault, in_reset ? "R12" : "R10 fault", 64'(fault), 64'(e_fault));
            chk(mem_req == e_req, t, 64'(mem_req), 64'(e_req));
            chk(instr_ready == !m_busy, in_reset ? "R12" : "R11 ready", 64'(instr_ready), 64'(!m_busy));
            if (e_opv) begin
                chk(op_data == e_data, data_tag(m_it), 64'(op_data), 64'(e_data));
                chk(op_addr == e_addr, (m_ix == 0) ? "R2" : "R3", 64'(op_addr), 64'(e_addr));
                chk(op_func == e_func && op_bcond == e_bc, "R1",
                    64'({op_func, op_bcond}), 64'({e_func, e_bc}));
            end
            if (e_req) chk(mem_addr == e_addr, "R9 mem_addr", 64'(mem_addr), 64'(e_addr));
        end
        if (mem_ack) begin
            mem_ack = 1'b0;
            mem_cnt = 0;
        end else if (mem_req) begin
            if (mem_cnt >= mem_delay) begin
                mem_ack = 1'b1;
                mem_rdata = {mem_addr ^ salt_hi, mem_addr ^ salt_lo};
            end else begin
                mem_cnt++;
            end
        end
    end

    task automatic issue(logic [5:0] f, logic [2:0] bc, logic [2:0] it, logic [2:0] ix,
                         logic [HW-1:0] d, logic [WW-1:0] acc, logic [HW-1:0] shi,
                         logic [HW-1:0] slo, int dly, bit junk);
        @(negedge clk);
        while (!instr_ready) @(negedge clk);
        salt_hi = shi;
        salt_lo = slo;
        mem_delay = dly;
        acc_in = acc;
        instr_word = {f, bc, it, ix, d};
        instr_valid = 1'b1;
        @(negedge clk);
        if (junk) begin
            // R11: a different word presented while busy must be ignored.
            instr_word = {6'o55, 3'd5, 3'd0, 3'd2, 15'h1111};
            @(negedge clk);
        end
        instr_valid = 1'b0;
    endtask

    initial begin
        logic [HW-1:0] dlist [6];
        logic [2:0]    xlist [6];
        xreg[0] = 15'h0000; xreg[1] = 15'h0001; xreg[2] = 15'h7FFE; xreg[3] = 15'h7FFF;
        xreg[4] = 15'h1234; xreg[5] = 15'h0000; xreg[6] = 15'h4000; xreg[7] = 15'h2AAA;
        dlist[0] = 15'h0000; dlist[1] = 15'h7FFF; dlist[2] = 15'h0001;
        dlist[3] = 15'h4321; dlist[4] = 15'h7FFE; dlist[5] = 15'h0ABC;
        xlist[0] = 3'd0; xlist[1] = 3'd1; xlist[2] = 3'd2;
        xlist[3] = 3'd3; xlist[4] = 3'd6; xlist[5] = 3'd7;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R4..R8, R2, R3: every interpretation across index selections.
        for (int it = 0; it < 8; it++) begin
            for (int k = 0; k < 6; k++) begin
                issue(6'(8 + it), 3'(k), 3'(it), xlist[k], dlist[(k + it) % 6],
                      {15'(k * 4661), 15'(it * 3001 + 16384)},
                      15'(k * 4369) ^ 15'h4000, 15'(it * 9000), (it + k) % 4, 0);
            end
        end
        // R3 corner: zero designator with zero index value gives zero.
        issue(6'o12, 3'd1, 3'd0, 3'd5, 15'h0000, '0, '0, '0, 0, 0);
        // R3 corner: two negative zeros stay negative zero.
        issue(6'o12, 3'd2, 3'd4, 3'd3, 15'h7FFF, '0, '0, '0, 0, 0);
        // R3 corner: 1 plus negative one gives negative zero, not zero.
        issue(6'o12, 3'd3, 3'd0, 3'd2, 15'h0001, '0, '0, '0, 0, 0);
        // R10: illegal function codes, one with a memory interpretation.
        issue(6'o00, 3'd0, 3'd3, 3'd1, 15'h0100, '0, '0, '0, 0, 0);
        issue(6'o77, 3'd7, 3'd7, 3'd0, 15'h0200, 30'h2AAAAAAA, '0, '0, 0, 0);
        // R11: junk offered while a memory read is outstanding.
        issue(6'o21, 3'd6, 3'd6, 3'd4, 15'h0777, '0, 15'h7000, 15'h0F0F, 3, 1);
        issue(6'o22, 3'd1, 3'd5, 3'd0, 15'h4000, '0, 15'h4000, 15'h0000, 2, 1);
        // R8 back-to-back accumulator reads with changing accumulator.
        issue(6'o40, 3'd0, 3'd7, 3'd0, 15'h0000, 30'h3FFFFFFF, '0, '0, 0, 0);
        issue(6'o40, 3'd0, 3'd7, 3'd0, 15'h0000, 30'h00000001, '0, '0, 0, 0);
        repeat (8) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule